// File: doc/BRIEF.md
# Masked-write PHY configuration bank

This block is a small set of configuration registers that sits between a 32-bit register bus and a storage-interface PHY. It contains seven 16-bit control registers and one read-only status word. Each control bit is wired straight out to the PHY, either as a named field or as a raw vector. The status word is assembled from PHY input pins.

A write never needs a read-modify-write. The upper half of the write word is a per-bit enable for the lower half. Software can therefore raise the PHY's power-up bit, or change the DLL frequency select, in one bus cycle without touching any other bit. Reads return the addressed register in the low half of the word. The read data is registered and appears one cycle after the read request.

The frequency select field uses this encoding: 0 selects 200 MHz, 1 selects 50 MHz, 2 selects 100 MHz and 3 selects 150 MHz. After reset every control bit is zero. The PHY is then powered down with its DLL disabled, and software brings it up through a sequence of masked writes.

Top module: `phy_cfg_regs`

## Requirements
- R1: On a write to a control register, bit n (0..15) takes `bus_wdata[n]` whenever `bus_wdata[n+16]` is 1.
- R2: On a write to a control register, bit n keeps its previous value whenever `bus_wdata[n+16]` is 0.
- R3: Control registers decode at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Only an exact match decodes; misaligned addresses are unmapped. Registers 0x04 to 0x14 drive `aux_cfg[0]` to `aux_cfg[4]` as raw 16-bit values. Reading a control register returns its contents in bits 15:0.
- R4: Register 0x00 drives fields as follows:
  - `freq_sel` from bits 13:12, encoded 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz;
  - `otap_en` from bit 11;
  - `otap_sel` from bits 10:7;
  - `itap_win` from bit 6;
  - `itap_sel` from bits 5:1;
  - `itap_en` from bit 0.
- R5: Register 0x18 drives fields as follows:
  - `dll_icp_trim` from bits 12:9;
  - `rtrim_en` from bit 8;
  - `rtrim_go` from bit 7;
  - `drv_type` from bits 6:4;
  - `retain` from bits 3:2;
  - `dll_en` from bit 1;
  - `phy_pwr_up` from bit 0 (1 = powered).
- R6: A read of offset 0x20 returns the status pins: `st_cal_done` in bit 6, `st_dll_ready` in bit 5, `st_trim_code` in bits 4:1 and `st_ext_res` in bit 0, with zeros in all other bits.
- R7: Writes to offset 0x20 or to any unmapped offset leave every control register unchanged.
- R8: A read of an unmapped offset returns zero.
- R9: Bits 31:16 of `bus_rdata` are always zero.
- R10: Reset (`rst_n` low) clears every control register and `bus_rdata` to zero, so `phy_pwr_up` and `dll_en` are 0.
- R11: `bus_rdata` updates on the clock edge that samples a read, which is one cycle after the request. It holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write enables [31:16], write data [15:0] |
| bus_rdata | output | 32 | Registered read data |
| st_cal_done | input | 1 | PHY calibration finished |
| st_dll_ready | input | 1 | PHY DLL locked |
| st_trim_code | input | 4 | Resistor trim result |
| st_ext_res | input | 1 | External resistor present |
| freq_sel | output | 2 | DLL frequency select |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap select |
| itap_win | output | 1 | Input tap change window |
| itap_sel | output | 5 | Input tap select |
| itap_en | output | 1 | Input tap enable |
| aux_cfg | output | 5x16 | Raw control registers 0x04..0x14 |
| dll_icp_trim | output | 4 | DLL charge-pump trim |
| rtrim_en | output | 1 | Resistor trim enable |
| rtrim_go | output | 1 | Resistor retrim request |
| drv_type | output | 3 | Driver strength type |
| retain | output | 2 | Retention controls |
| dll_en | output | 1 | DLL enable |
| phy_pwr_up | output | 1 | PHY power-up (active high) |

## Verification
A stored bit that is wrong in any control register shows up on the field outputs on the very next clock edge. A readback of that register one cycle later shows the same error. A bad write enable, such as an inverted or shifted mask lane, would flip or keep the wrong bits, and the bench compares every output field against a behavioural register image on every clock. A decode fault is the quieter case: it writes into a neighbouring register or returns stale status. The bench therefore reads back every offset after writes to the status, unmapped and misaligned addresses, so the error surfaces within two cycles of that readback.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int unsigned NUM_CTRL   = 7;
  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned STATUS_IDX = 8;   // status word sits at 8 * stride
  localparam int unsigned STAT_W     = 7;

  // Field layout of control register 0 (bits 13:0)
  typedef struct packed {
    logic [1:0] freq;
    logic       otap_en;
    logic [3:0] otap_sel;
    logic       itap_win;
    logic [4:0] itap_sel;
    logic       itap_en;
  } tap_cfg_t;

  // Field layout of control register 6 (bits 12:0)
  typedef struct packed {
    logic [3:0] icp_trim;
    logic       rtrim_en;
    logic       rtrim_go;
    logic [2:0] drv;
    logic [1:0] retain;
    logic       dll_en;
    logic       pwr_up;
  } pwr_cfg_t;

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_CTRL   = 7,
  parameter int unsigned REG_STRIDE = 4,
  parameter int unsigned STATUS_IDX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_hit,
  output logic                stat_hit,
  output logic                miss
);

  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(STATUS_IDX * REG_STRIDE);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
    assign ctrl_hit[i] = (addr == ADDR_W'(i * REG_STRIDE));
  end

  assign stat_hit = (addr == STAT_OFF);
  assign miss     = ~stat_hit & ~(|ctrl_hit);

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_hit, stat_hit}));

endmodule

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hit,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W/2-1:0]   q
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] bit_en;
  logic [HALF_W-1:0] bit_val;
  logic [HALF_W-1:0] q_nxt;

  assign bit_en  = wdata[DATA_W-1:HALF_W];
  assign bit_val = wdata[HALF_W-1:0];

  always_comb begin
    q_nxt = q;
    if (wr_hit) begin
      q_nxt = (q & ~bit_en) | (bit_val & bit_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_hit) begin
      q <= q_nxt;
    end
  end

  // R1
  take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((q ^ $past(wdata[HALF_W-1:0])) & $past(wdata[DATA_W-1:HALF_W])) == '0));

  // R2
  keep_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((q ^ $past(q)) & ~$past(wdata[DATA_W-1:HALF_W])) == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CTRL = 7,
  parameter int unsigned STAT_W   = 7
) (
  input  logic [NUM_CTRL-1:0]                ctrl_hit,
  input  logic                               stat_hit,
  input  logic [NUM_CTRL-1:0][DATA_W/2-1:0]  ctrl_q,
  input  logic [STAT_W-1:0]                  stat_word,
  output logic [DATA_W-1:0]                  rd_word
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] low_half;

  always_comb begin
    low_half = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (ctrl_hit[i]) begin
        low_half = low_half | ctrl_q[i];
      end
    end
    if (stat_hit) begin
      low_half = low_half | HALF_W'(stat_word);
    end
  end

  assign rd_word = {{HALF_W{1'b0}}, low_half};

endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
  import phy_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  st_cal_done,
  input  logic                  st_dll_ready,
  input  logic [3:0]            st_trim_code,
  input  logic                  st_ext_res,
  output logic [1:0]            freq_sel,
  output logic                  otap_en,
  output logic [3:0]            otap_sel,
  output logic                  itap_win,
  output logic [4:0]            itap_sel,
  output logic                  itap_en,
  output logic [4:0][15:0]      aux_cfg,
  output logic [3:0]            dll_icp_trim,
  output logic                  rtrim_en,
  output logic                  rtrim_go,
  output logic [2:0]            drv_type,
  output logic [1:0]            retain,
  output logic                  dll_en,
  output logic                  phy_pwr_up
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned TAP_W  = $bits(tap_cfg_t);
  localparam int unsigned PWR_W  = $bits(pwr_cfg_t);

  logic [NUM_CTRL-1:0]              ctrl_hit;
  logic                             stat_hit;
  logic                             addr_miss;
  logic [NUM_CTRL-1:0][HALF_W-1:0]  ctrl_q;
  logic [STAT_W-1:0]                stat_word;
  logic [DATA_W-1:0]                rd_word;
  logic                             rd_fire;
  logic                             wr_fire;
  logic [DATA_W-1:0]                rdata_nxt;
  tap_cfg_t                         tap_f;
  pwr_cfg_t                         pwr_f;
  logic                             unused_bits;

  assign rd_fire = bus_sel & ~bus_wr;
  assign wr_fire = bus_sel &  bus_wr;

  cfg_addr_dec #(
    .ADDR_W     (ADDR_W),
    .NUM_CTRL   (NUM_CTRL),
    .REG_STRIDE (REG_STRIDE),
    .STATUS_IDX (STATUS_IDX)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .ctrl_hit (ctrl_hit),
    .stat_hit (stat_hit),
    .miss     (addr_miss)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    cfg_mask_reg #(
      .DATA_W (DATA_W)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_fire & ctrl_hit[i]),
      .wdata  (bus_wdata),
      .q      (ctrl_q[i])
    );
  end

  assign stat_word = {st_cal_done, st_dll_ready, st_trim_code, st_ext_res};

  cfg_read_mux #(
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL),
    .STAT_W   (STAT_W)
  ) u_mux (
    .ctrl_hit  (ctrl_hit),
    .stat_hit  (stat_hit),
    .ctrl_q    (ctrl_q),
    .stat_word (stat_word),
    .rd_word   (rd_word)
  );

  always_comb begin
    rdata_nxt = bus_rdata;
    if (rd_fire) begin
      rdata_nxt = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_fire) begin
      bus_rdata <= rdata_nxt;
    end
  end

  // Field fan-out
  assign tap_f = ctrl_q[0][TAP_W-1:0];
  assign pwr_f = ctrl_q[NUM_CTRL-1][PWR_W-1:0];

  assign freq_sel     = tap_f.freq;
  assign otap_en      = tap_f.otap_en;
  assign otap_sel     = tap_f.otap_sel;
  assign itap_win     = tap_f.itap_win;
  assign itap_sel     = tap_f.itap_sel;
  assign itap_en      = tap_f.itap_en;

  for (genvar j = 0; j < 5; j++) begin : g_aux
    assign aux_cfg[j] = ctrl_q[j+1];
  end

  assign dll_icp_trim = pwr_f.icp_trim;
  assign rtrim_en     = pwr_f.rtrim_en;
  assign rtrim_go     = pwr_f.rtrim_go;
  assign drv_type     = pwr_f.drv;
  assign retain       = pwr_f.retain;
  assign dll_en       = pwr_f.dll_en;
  assign phy_pwr_up   = pwr_f.pwr_up;

  assign unused_bits = ^{ctrl_q[0][HALF_W-1:TAP_W], ctrl_q[NUM_CTRL-1][HALF_W-1:PWR_W]};

  // R8
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && addr_miss) |=> (bus_rdata == '0));

  // R9
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:HALF_W] == '0);

  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (stat_hit || addr_miss)) |=> $stable(ctrl_q));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(bus_rdata));

  // R6
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && stat_hit) |=> (bus_rdata == DATA_W'($past(stat_word))));

endmodule

// File: tb/tb_phy_cfg_regs.sv
`timescale 1ns/1ps
module tb_phy_cfg_regs;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        st_cal_done;
  logic        st_dll_ready;
  logic [3:0]  st_trim_code;
  logic        st_ext_res;
  logic [1:0]  freq_sel;
  logic        otap_en;
  logic [3:0]  otap_sel;
  logic        itap_win;
  logic [4:0]  itap_sel;
  logic        itap_en;
  logic [4:0][15:0] aux_cfg;
  logic [3:0]  dll_icp_trim;
  logic        rtrim_en;
  logic        rtrim_go;
  logic [2:0]  drv_type;
  logic [1:0]  retain;
  logic        dll_en;
  logic        phy_pwr_up;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit live   = 0;

  phy_cfg_regs dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  // Behavioural reference image
  logic [15:0] m_reg [7];
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) m_reg[i] = 16'h0;
      m_rd = 32'h0;
    end else if (bus_sel) begin
      if (bus_wr) begin
        if (bus_addr[1:0] == 2'b00 && bus_addr < 8'h1C) begin
          for (int b = 0; b < 16; b++)
            if (bus_wdata[b+16]) m_reg[bus_addr/4][b] = bus_wdata[b];
        end
      end else begin
        if (bus_addr[1:0] == 2'b00 && bus_addr < 8'h1C)
          m_rd = {16'h0, m_reg[bus_addr/4]};
        else if (bus_addr == 8'h20)
          m_rd = {25'h0, st_cal_done, st_dll_ready, st_trim_code, st_ext_res};
        else
          m_rd = 32'h0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R4", {18'h0, freq_sel, otap_en, otap_sel, itap_win, itap_sel, itap_en},
          {18'h0, m_reg[0][13:0]});
      chk("R5", {19'h0, dll_icp_trim, rtrim_en, rtrim_go, drv_type, retain, dll_en, phy_pwr_up},
          {19'h0, m_reg[6][12:0]});
      for (int k = 0; k < 5; k++) chk("R3", {16'h0, aux_cfg[k]}, {16'h0, m_reg[k+1]});
      chk("R11", bus_rdata, m_rd);
    end
  end

  task automatic op(input logic w, input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    op(1'b0, a, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    st_cal_done = 0; st_dll_ready = 0; st_trim_code = 0; st_ext_res = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {30'h0, phy_pwr_up, dll_en}, 32'h0);
    chk("R10", bus_rdata, 32'h0);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    rd(8'h18); chk("R10", bus_rdata, 32'h0);

    // R1 full-mask write, R3 readback, R4 fields
    op(1'b1, 8'h00, 32'hFFFF_2A5B);
    rd(8'h00); chk("R3", bus_rdata, 32'h0000_2A5B);
    chk("R4", {30'h0, freq_sel}, 32'd2);
    chk("R4", {28'h0, otap_sel}, 32'd4);
    chk("R4", {27'h0, itap_sel}, 32'd13);
    chk("R1", {31'h0, itap_en}, 32'd1);

    // R2 partial mask clears only bits 7:4
    op(1'b1, 8'h00, 32'h00F0_0000);
    rd(8'h00); chk("R2", bus_rdata, 32'h0000_2A0B);

    // R5 power-up then field write
    op(1'b1, 8'h18, 32'h0003_FFFF);
    chk("R5", {30'h0, dll_en, phy_pwr_up}, 32'd3);
    op(1'b1, 8'h18, 32'h1E70_1250);
    chk("R5", {28'h0, dll_icp_trim}, 32'd9);
    chk("R5", {29'h0, drv_type}, 32'd5);
    rd(8'h18); chk("R2", bus_rdata, 32'h0000_1253);

    // R7 stray writes
    op(1'b1, 8'h20, 32'hFFFF_FFFF);
    op(1'b1, 8'h1C, 32'hFFFF_FFFF);
    op(1'b1, 8'h02, 32'hFFFF_FFFF);
    op(1'b1, 8'h40, 32'hFFFF_FFFF);
    rd(8'h00); chk("R7", bus_rdata, 32'h0000_2A0B);
    rd(8'h18); chk("R7", bus_rdata, 32'h0000_1253);
    for (int a = 4; a < 24; a += 4) begin
      rd(8'(a)); chk("R7", bus_rdata, 32'h0);
    end

    // R6 status
    st_cal_done = 1; st_dll_ready = 0; st_trim_code = 4'hA; st_ext_res = 1;
    rd(8'h20); chk("R6", bus_rdata, 32'h0000_0055);
    st_cal_done = 0; st_dll_ready = 1; st_trim_code = 4'h3; st_ext_res = 0;
    rd(8'h20); chk("R6", bus_rdata, 32'h0000_0026);

    // R8 unmapped reads
    rd(8'h24); chk("R8", bus_rdata, 32'h0);
    rd(8'h20);
    rd(8'h1C); chk("R8", bus_rdata, 32'h0);
    rd(8'h20);
    rd(8'h05); chk("R8", bus_rdata, 32'h0);

    // R9 upper half, R11 hold
    op(1'b1, 8'h04, 32'hFFFF_FFFF);
    rd(8'h04); chk("R9", bus_rdata, 32'h0000_FFFF);
    op(1'b1, 8'h04, 32'hFFFF_0000);
    chk("R11", bus_rdata, 32'h0000_FFFF);
    @(negedge clk);
    chk("R11", bus_rdata, 32'h0000_FFFF);
    chk("R3", {16'h0, aux_cfg[0]}, 32'h0);

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      a = (pick == 7) ? 8'($urandom) : 8'(pick * 4 + ((pick == 7) ? 0 : 0));
      if (pick == 7 && $urandom_range(0, 1) == 1) a = 8'h20;
      st_cal_done  = 1'($urandom);
      st_dll_ready = 1'($urandom);
      st_trim_code = 4'($urandom);
      st_ext_res   = 1'($urandom);
      case ($urandom_range(0, 2))
        0: op(1'b1, a, $urandom);
        1: rd(a);
        default: @(negedge clk);
      endcase
    end

    // R10 async reset mid-run
    rst_n = 0;
    #1;
    chk("R10", {30'h0, phy_pwr_up, dll_en}, 32'h0);
    chk("R10", {16'h0, aux_cfg[4]}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule